// File: doc/BRIEF.md
# Configurable Fixed-Point Multiply-Accumulate Slice

A pipelined signed fixed-point arithmetic slice. Depending on a mode select, one operand pair is split into four narrow products, two medium products, or one wide product. Each product keeps its own field on a lane output. All products of the current mode are also summed into a 64-bit value. That value can be accumulated into a running total, loaded fresh, or cleared.

A 64-bit cascade port lets several slices form a chain. When chaining is enabled, the cascade input of one slice is added into its sum, and its registered total drives its cascade output toward the next slice. The slice registers its inputs, then the products, then the total. A result therefore appears three clock edges after its operands, and a valid flag travels alongside it. The cascade input is captured together with the operands, so a chained neighbour has to present its operands three cycles after the upstream slice.

Top module: `mac_slice`

## Requirements
- R1: While reset is held, and after it is released, `out_valid`, `result`, `lanes_out` and `casc_out` are all zero until the first valid result appears.
- R2: A beat accepted with `in_valid` high produces `out_valid` high exactly three rising edges later, and every valid beat produces exactly one valid result, in order.
- R3: Mode 2'b00 (quad) forms four signed 9x9 products: `opa[9k+8:9k]` times `opb[9k+8:9k]` for k=0..3. Product k sits in `lanes_out[18k+17:18k]`, the top two lane bits are zero, and the sum is the total of the four products.
- R4: Mode 2'b01 (dual) forms two signed products: `opa[18k+17:18k]` (18 bits) times `opb[19k+18:19k]` (19 bits) for k=0..1. Each 37-bit product sits in `lanes_out[37k+36:37k]`, and the sum is the total of both products.
- R5: Modes 2'b10 and 2'b11 (single) form one signed 27x27 product of `opa[26:0]` and `opb[26:0]`. It appears sign-extended across all of `lanes_out`, and the sum equals that product.
- R6: With `acc_en` high and `acc_load` and `acc_clr` low, the new total is the previous total plus the beat's sum.
- R7: With `acc_load` high, or with `acc_en` low, the new total is the beat's sum alone, and any earlier total is discarded.
- R8: `acc_clr` forces the new total to zero, whatever `acc_load`, `acc_en` and `chain_en` are.
- R9: The beat's sum includes `casc_in` only when `chain_en` is high. When `chain_en` is low, `casc_in` has no effect.
- R10: `casc_out` always equals `result`.
- R11: The total wraps modulo 2^64 and never saturates.
- R12: Beats with `in_valid` low leave `result` and `lanes_out` unchanged, whatever their operands and controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand beat is valid |
| mode | input | 2 | 00 quad, 01 dual, 10/11 single |
| acc_en | input | 1 | Add the beat's sum to the running total |
| acc_load | input | 1 | Replace the total with the beat's sum |
| acc_clr | input | 1 | Zero the total |
| chain_en | input | 1 | Include the cascade input in the sum |
| opa | input | 36 | Packed signed operands A |
| opb | input | 38 | Packed signed operands B |
| casc_in | input | 64 | Cascade input from the previous slice |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Running total |
| lanes_out | output | 74 | Packed per-product fields |
| casc_out | output | 64 | Cascade output to the next slice |

## Verification
The assertions assume that reset is held for at least two edges with `in_valid` low, and that `mode` does not change while a beat is inside the pipeline. The dual-mode sum check also assumes that the mode recorded with a beat is the mode that formed its products. The stimulus applies every beat at the falling edge, keeps `in_valid` low throughout reset, and sets `mode` together with the operands of each beat. The stimulus also sends the invalid beats with clear asserted and junk operands, which confirms that the hold property is exercised under the worst case.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

  typedef enum logic [1:0] {
    MODE_QUAD   = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_SINGLE = 2'b10,
    MODE_WIDE   = 2'b11
  } mac_mode_e;

  typedef struct packed {
    logic acc_en;
    logic load;
    logic clr;
    logic chain_en;
  } mac_ctrl_t;

  function automatic int max3(input int x, input int y, input int z);
    int m;
    m = (x > y) ? x : y;
    return (m > z) ? m : z;
  endfunction

endpackage

// File: rtl/mac_input_stage.sv
module mac_input_stage
  import mac_slice_pkg::*;
#(
  parameter int OPA_W = 36,
  parameter int OPB_W = 38,
  parameter int ACC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       mode_i,
  input  mac_ctrl_t        ctrl_i,
  input  logic [OPA_W-1:0] opa_i,
  input  logic [OPB_W-1:0] opb_i,
  input  logic [ACC_W-1:0] casc_i,
  output logic             v1_o,
  output mac_mode_e        mode1_o,
  output mac_ctrl_t        ctrl1_o,
  output logic [OPA_W-1:0] a1_o,
  output logic [OPB_W-1:0] b1_o,
  output logic [ACC_W-1:0] casc1_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_o    <= 1'b0;
      mode1_o <= MODE_QUAD;
      ctrl1_o <= '0;
      a1_o    <= '0;
      b1_o    <= '0;
      casc1_o <= '0;
    end else begin
      v1_o    <= in_valid;
      mode1_o <= mac_mode_e'(mode_i);
      ctrl1_o <= ctrl_i;
      a1_o    <= opa_i;
      b1_o    <= opb_i;
      casc1_o <= casc_i;
    end
  end

endmodule

// File: rtl/mac_mult_array.sv
module mac_mult_array
  import mac_slice_pkg::*;
#(
  parameter int Q_W    = 9,
  parameter int DA_W   = 18,
  parameter int DB_W   = 19,
  parameter int S_W    = 27,
  parameter int OPA_W  = 36,
  parameter int OPB_W  = 38,
  parameter int LANE_W = 74,
  parameter int ACC_W  = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    v1_i,
  input  mac_mode_e               mode1_i,
  input  mac_ctrl_t               ctrl1_i,
  input  logic [OPA_W-1:0]        a1_i,
  input  logic [OPB_W-1:0]        b1_i,
  input  logic [ACC_W-1:0]        casc1_i,
  output logic                    v2_o,
  output mac_ctrl_t               ctrl2_o,
  output logic [LANE_W-1:0]       lanes2_o,
  output logic signed [ACC_W-1:0] sum2_o,
  output logic [ACC_W-1:0]        casc2_o
);

  localparam int QUAD_N = 4;
  localparam int DUAL_N = 2;
  localparam int QP_W   = 2 * Q_W;
  localparam int DP_W   = DA_W + DB_W;
  localparam int SP_W   = 2 * S_W;

  logic signed [QP_W-1:0] qprod [QUAD_N];
  logic signed [DP_W-1:0] dprod [DUAL_N];
  logic signed [SP_W-1:0] sprod;

  for (genvar gi = 0; gi < QUAD_N; gi++) begin : g_quad
    assign qprod[gi] = QP_W'($signed(a1_i[gi*Q_W +: Q_W])) *
                       QP_W'($signed(b1_i[gi*Q_W +: Q_W]));
  end

  for (genvar gj = 0; gj < DUAL_N; gj++) begin : g_dual
    assign dprod[gj] = DP_W'($signed(a1_i[gj*DA_W +: DA_W])) *
                       DP_W'($signed(b1_i[gj*DB_W +: DB_W]));
  end

  assign sprod = SP_W'($signed(a1_i[S_W-1:0])) * SP_W'($signed(b1_i[S_W-1:0]));

  logic [LANE_W-1:0]       lanes_d;
  logic signed [ACC_W-1:0] sum_d;

  always_comb begin
    lanes_d = '0;
    sum_d   = '0;
    unique case (mode1_i)
      MODE_QUAD: begin
        for (int k = 0; k < QUAD_N; k++) begin
          lanes_d[k*QP_W +: QP_W] = qprod[k];
          sum_d = sum_d + ACC_W'(qprod[k]);
        end
      end
      MODE_DUAL: begin
        for (int k = 0; k < DUAL_N; k++) begin
          lanes_d[k*DP_W +: DP_W] = dprod[k];
          sum_d = sum_d + ACC_W'(dprod[k]);
        end
      end
      default: begin
        lanes_d = LANE_W'(sprod);
        sum_d   = ACC_W'(sprod);
      end
    endcase
  end

  mac_mode_e mode2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v2_o     <= 1'b0;
      ctrl2_o  <= '0;
      lanes2_o <= '0;
      sum2_o   <= '0;
      casc2_o  <= '0;
      mode2_q  <= MODE_QUAD;
    end else begin
      v2_o     <= v1_i;
      ctrl2_o  <= ctrl1_i;
      lanes2_o <= lanes_d;
      sum2_o   <= sum_d;
      casc2_o  <= casc1_i;
      mode2_q  <= mode1_i;
    end
  end

  // Dual mode: the registered sum must agree with the two registered fields
  assert_dual_sum_R4: assert property (@(posedge clk) disable iff (rst)
    (v2_o && mode2_q == MODE_DUAL) |->
      sum2_o == ACC_W'($signed(lanes2_o[DP_W-1:0])) + ACC_W'($signed(lanes2_o[2*DP_W-1:DP_W])));

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_slice_pkg::*;
#(
  parameter int LANE_W = 74,
  parameter int ACC_W  = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    v2_i,
  input  mac_ctrl_t               ctrl2_i,
  input  logic [LANE_W-1:0]       lanes2_i,
  input  logic signed [ACC_W-1:0] sum2_i,
  input  logic [ACC_W-1:0]        casc2_i,
  output logic                    out_valid_o,
  output logic [ACC_W-1:0]        acc_o,
  output logic [LANE_W-1:0]       lanes_o
);

  logic             do_acc;
  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] acc_next;

  assign do_acc = ctrl2_i.acc_en && !ctrl2_i.load;
  assign addend = sum2_i + (ctrl2_i.chain_en ? casc2_i : '0);

  always_comb begin
    if (ctrl2_i.clr)  acc_next = '0;
    else if (do_acc)  acc_next = acc_o + addend;
    else              acc_next = addend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      acc_o       <= '0;
      lanes_o     <= '0;
    end else begin
      out_valid_o <= v2_i;
      if (v2_i) begin
        acc_o   <= acc_next;
        lanes_o <= lanes2_i;
      end
    end
  end

  logic past_rst;
  always_ff @(posedge clk) past_rst <= rst;

  assert_valid_track_R2: assert property (@(posedge clk) disable iff (rst || past_rst)
    out_valid_o == $past(v2_i));

  assert_accum_R6: assert property (@(posedge clk) disable iff (rst || past_rst)
    $past(v2_i && ctrl2_i.acc_en && !ctrl2_i.load && !ctrl2_i.clr) |->
      acc_o == $past(acc_o) + $past(addend));

  assert_replace_R7: assert property (@(posedge clk) disable iff (rst || past_rst)
    $past(v2_i && !ctrl2_i.clr && (ctrl2_i.load || !ctrl2_i.acc_en)) |->
      acc_o == $past(addend));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst || past_rst)
    $past(v2_i && ctrl2_i.clr) |-> acc_o == '0);

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst || past_rst)
    !$past(v2_i) |-> ($stable(acc_o) && $stable(lanes_o)));

endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_slice_pkg::*;
#(
  parameter int  Q_W    = 9,
  parameter int  DA_W   = 18,
  parameter int  DB_W   = 19,
  parameter int  S_W    = 27,
  parameter int  ACC_W  = 64,
  localparam int OPA_W  = max3(4 * Q_W, 2 * DA_W, S_W),
  localparam int OPB_W  = max3(4 * Q_W, 2 * DB_W, S_W),
  localparam int LANE_W = max3(8 * Q_W, 2 * (DA_W + DB_W), 2 * S_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic              acc_en,
  input  logic              acc_load,
  input  logic              acc_clr,
  input  logic              chain_en,
  input  logic [OPA_W-1:0]  opa,
  input  logic [OPB_W-1:0]  opb,
  input  logic [ACC_W-1:0]  casc_in,
  output logic              out_valid,
  output logic [ACC_W-1:0]  result,
  output logic [LANE_W-1:0] lanes_out,
  output logic [ACC_W-1:0]  casc_out
);

  mac_ctrl_t ctrl_in;
  assign ctrl_in = '{acc_en: acc_en, load: acc_load, clr: acc_clr, chain_en: chain_en};

  logic                    v1, v2;
  mac_mode_e               mode1;
  mac_ctrl_t               ctrl1, ctrl2;
  logic [OPA_W-1:0]        a1;
  logic [OPB_W-1:0]        b1;
  logic [ACC_W-1:0]        casc1, casc2;
  logic [LANE_W-1:0]       lanes2;
  logic signed [ACC_W-1:0] sum2;

  mac_input_stage #(.OPA_W(OPA_W), .OPB_W(OPB_W), .ACC_W(ACC_W)) u_in (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_i(mode), .ctrl_i(ctrl_in),
    .opa_i(opa), .opb_i(opb), .casc_i(casc_in),
    .v1_o(v1), .mode1_o(mode1), .ctrl1_o(ctrl1), .a1_o(a1), .b1_o(b1), .casc1_o(casc1)
  );

  mac_mult_array #(
    .Q_W(Q_W), .DA_W(DA_W), .DB_W(DB_W), .S_W(S_W),
    .OPA_W(OPA_W), .OPB_W(OPB_W), .LANE_W(LANE_W), .ACC_W(ACC_W)
  ) u_mul (
    .clk(clk), .rst(rst), .v1_i(v1), .mode1_i(mode1), .ctrl1_i(ctrl1),
    .a1_i(a1), .b1_i(b1), .casc1_i(casc1),
    .v2_o(v2), .ctrl2_o(ctrl2), .lanes2_o(lanes2), .sum2_o(sum2), .casc2_o(casc2)
  );

  mac_accum #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .v2_i(v2), .ctrl2_i(ctrl2), .lanes2_i(lanes2),
    .sum2_i(sum2), .casc2_i(casc2),
    .out_valid_o(out_valid), .acc_o(result), .lanes_o(lanes_out)
  );

  assign casc_out = result;

endmodule

// File: tb/mac_slice_tb_top.sv
module mac_slice_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  mode;
  logic        acc_en, acc_load, acc_clr, chain_en;
  logic [35:0] opa;
  logic [37:0] opb;
  logic [63:0] casc_in;
  logic        out_valid;
  logic [63:0] result;
  logic [73:0] lanes_out;
  logic [63:0] casc_out;

  always #4 clk = ~clk;

  mac_slice dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .acc_en(acc_en), .acc_load(acc_load), .acc_clr(acc_clr), .chain_en(chain_en),
    .opa(opa), .opb(opb), .casc_in(casc_in),
    .out_valid(out_valid), .result(result), .lanes_out(lanes_out), .casc_out(casc_out)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  logic [63:0] exp_res_q [$];
  logic [73:0] exp_lane_q [$];
  int          exp_cyc_q [$];
  string       exp_tag_q [$];
  logic [63:0] model_acc = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check74(input string tag, input logic [73:0] act, input logic [73:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one valid beat and queues the expected result
  task automatic drive(input string tag, input logic [1:0] m, input logic [35:0] a,
                       input logic [37:0] b, input bit en, input bit ld, input bit cl,
                       input bit ch, input logic [63:0] cin);
    logic [73:0] lanes;
    logic [63:0] sum;
    lanes = '0;
    sum   = '0;
    if (m == 2'b00) begin
      for (int k = 0; k < 4; k++) begin
        longint p;
        p = longint'($signed(a[9*k +: 9])) * longint'($signed(b[9*k +: 9]));
        lanes[18*k +: 18] = p[17:0];
        sum = sum + 64'(p);
      end
    end else if (m == 2'b01) begin
      for (int k = 0; k < 2; k++) begin
        longint p;
        p = longint'($signed(a[18*k +: 18])) * longint'($signed(b[19*k +: 19]));
        lanes[37*k +: 37] = p[36:0];
        sum = sum + 64'(p);
      end
    end else begin
      longint p;
      logic signed [73:0] t;
      p = longint'($signed(a[26:0])) * longint'($signed(b[26:0]));
      t = p;
      lanes = t;
      sum = 64'(p);
    end
    if (ch) sum = sum + cin;
    if (cl)             model_acc = '0;
    else if (en && !ld) model_acc = model_acc + sum;
    else                model_acc = sum;
    exp_res_q.push_back(model_acc);
    exp_lane_q.push_back(lanes);
    exp_cyc_q.push_back(cyc);
    exp_tag_q.push_back(tag);
    mode = m; opa = a; opb = b;
    acc_en = en; acc_load = ld; acc_clr = cl; chain_en = ch; casc_in = cin;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Invalid beats with hostile controls and junk operands
  task automatic idle_junk(input int n);
    for (int i = 0; i < n; i++) begin
      mode = 2'(i); opa = {9{4'hA}}; opb = {19{2'b10}};
      acc_en = 1'b1; acc_load = 1'b0; acc_clr = 1'b1; chain_en = 1'b1;
      casc_in = 64'hDEAD_BEEF_0123_4567; in_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  // Monitor: pops and compares each valid result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_res_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R2: unexpected out_valid, actual 1 expected 0");
      end else begin
        string tag;
        int c0;
        tag = exp_tag_q.pop_front();
        c0  = exp_cyc_q.pop_front();
        check64({tag, " result"}, result, exp_res_q.pop_front());
        check74({tag, " lanes"}, lanes_out, exp_lane_q.pop_front());
        check64({"R10 casc_out ", tag}, casc_out, result);
        check64({"R2 latency ", tag}, 64'(cyc - c0), 64'd3);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; mode = 2'b00; opa = '0; opb = '0;
    acc_en = 0; acc_load = 0; acc_clr = 0; chain_en = 0; casc_in = '0;
    repeat (4) @(negedge clk);
    check64("R1 reset out_valid", 64'(out_valid), 64'd0);
    check64("R1 reset result", result, 64'd0);
    check74("R1 reset lanes", lanes_out, 74'd0);
    check64("R1 reset casc_out", casc_out, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check64("R1 after release result", result, 64'd0);

    // R3 quad lanes, extremes included (-256 * -256)
    drive("R3 quad", 2'b00, {9'h100, 9'h0FF, 9'h1FD, 9'h005},
          {2'b11, 9'h100, 9'h1FF, 9'h064, 9'h007}, 0, 0, 0, 0, '0);
    // R4 dual lanes with 18-bit minimum and 19-bit maximum
    drive("R4 dual", 2'b01, {18'd1234, 18'h20000},
          {19'h7E9D2, 19'h3FFFF}, 0, 0, 0, 0, '0);
    // R5 single mode, both encodings
    drive("R5 single", 2'b10, 36'(27'h4000000), 38'(27'h4000000), 0, 0, 0, 0, '0);
    drive("R5 single alt", 2'b11, {9'h1AB, 27'h3FFFFFF}, {11'h5A5, 27'h4000001}, 0, 0, 0, 0, '0);

    // R7 load starts a new total, R6 accumulates back to back
    drive("R7 load", 2'b10, 36'd1000, 38'd3000, 1, 1, 0, 0, '0);
    drive("R6 acc1", 2'b10, 36'(27'h7FFFFFF), 38'd77, 1, 0, 0, 0, '0);
    drive("R6 acc2", 2'b10, 36'd5, 38'd9, 1, 0, 0, 0, '0);
    drive("R6 acc quad", 2'b00, {9'd3, 9'd2, 9'd1, 9'h1FF}, {2'b0, 9'd4, 9'd4, 9'd4, 9'd4}, 1, 0, 0, 0, '0);
    // R8 clear wins over load, accumulate and chain
    drive("R8 clear", 2'b01, 36'd55, 38'd66, 1, 1, 1, 1, 64'h1234);
    drive("R6 after clear", 2'b01, {18'd2, 18'd3}, {19'd5, 19'd7}, 1, 0, 0, 0, '0);

    // R9 cascade added only when chain_en is high
    drive("R9 chain on", 2'b10, 36'd10, 38'd10, 0, 0, 0, 1, 64'h0000_0100_0000_0000);
    drive("R9 chain off", 2'b10, 36'd10, 38'd10, 0, 0, 0, 0, 64'hFFFF_0000_FFFF_0000);
    drive("R9 chain quad", 2'b00, {9'd1, 9'd1, 9'd1, 9'd1}, {2'b0, 9'd1, 9'd1, 9'd1, 9'd1}, 1, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFF0);

    // R11 wrap past the positive limit
    drive("R11 wrap load", 2'b10, 36'd0, 38'd0, 1, 1, 0, 1, 64'h7FFF_FFFF_FFFF_FFFF);
    drive("R11 wrap add", 2'b10, 36'd1, 38'd1, 1, 0, 0, 0, '0);
    drive("R11 wrap under", 2'b10, 36'd0, 38'd0, 1, 0, 0, 1, 64'h8000_0000_0000_0000);

    repeat (4) @(negedge clk);
    // R12 invalid beats with clear asserted change nothing
    idle_junk(6);
    check64("R12 idle result", result, model_acc);
    check64("R12 idle casc_out", casc_out, model_acc);
    drive("R12 acc after idle", 2'b10, 36'd2, 38'd3, 1, 0, 0, 0, '0);

    repeat (6) @(negedge clk);
    check64("R2 all results seen", 64'(exp_res_q.size()), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule